// File: doc/BRIEF.md
# NAND Transfer Counter and Interrupt Control

This block sits between a DMA channel and the pin-timing engine of a single-level NAND flash controller. Software programs it through a small 32-bit register port. It picks the transfer direction and the request style, loads a byte count and sets a start bit. Bytes then stream through an internal byte FIFO. In write-to-flash mode they flow from the DMA side to the device side; in read-from-flash mode they flow the other way. The block asks the DMA for service with a request line and stops by itself once the programmed number of bytes has left the FIFO.

Two events can raise the interrupt line: transfer completion and a rising edge of the synchronised device-ready pin. Each event has a raw pending bit, an enable bit, a software set path and a software clear path. A control write can clear the whole block, and it can also emit a one-cycle pulse that resets the external ECC accumulator. The configuration bits that the pin engine and the ECC generator decode are brought out as plain outputs.

Top module: `nfc_xfer_ctrl`

## Requirements
- R1: After rst_ni is released, the configuration, interrupt-enable, pending, count and start state all read zero, and irq_o and dma_req_o are low. Register word addresses: 0 control, 1 configuration, 2 status, 3 raw pending (read), 4 enable, 5 set (write), 6 clear (write), 7 byte count.
- R2: A write to the byte-count register loads it only while the start bit (control bit 0) is clear. While a transfer runs, the write is ignored and the register keeps its value.
- R3: The count drops by exactly one for each byte that leaves the FIFO toward the sink. The source side is accepted only while the remaining count exceeds the FIFO occupancy, so exactly the programmed number of bytes enters and leaves, and the count reads zero at the end.
- R4: Configuration bit 1 selects the direction: 0 moves bytes from the DMA write port to the device transmit port, and 1 moves them from the device receive port to the DMA read port. Bytes keep their order. The ports of the unused direction stay idle (ready and valid low).
- R5: In the cycle after the start bit is set with the count at zero, the start bit clears and transfer-complete pending (bit 1) sets. A transfer ends exactly two cycles after its last byte leaves, as seen at the ports.
- R6: dma_req_o is low while no transfer runs. With configuration bit 2 clear, it is high whenever the DMA-side port can move a byte. With bit 2 set, it also needs the FIFO free space (write) or occupancy (read) to reach the smaller of BURST_LEN and the bytes still outstanding.
- R7: The status register shows the synchronised ready pin in bit 0, the pin engine's FIFO-busy input in bit 1, and a non-empty DMA FIFO in bit 2. The ready pin appears two clock edges after it changes.
- R8: Device-ready pending (bit 0) sets on a rising edge of the synchronised ready pin, one edge after status bit 0 rises. A falling edge sets nothing.
- R9: Writing ones to the set register raises those pending bits. Writing ones to the clear register lowers them, and a value of 3 clears both.
- R10: irq_o is high exactly when some pending bit has its enable bit set. Enable bits never alter the pending bits.
- R11: Writing control bit 2 resets, in one cycle, the start bit, configuration, enables, pending bits, count and FIFO contents. It wins over a start bit written in the same value.
- R12: Writing control bit 1 produces a one-cycle pulse on ecc_clr_o in the following cycle. Configuration bits 0, 3, 4 and 5 drive wide_bus_o, ecc_en_o, dma_ecc_o and ce_low_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 3 | Register word address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| nand_rdy_i | input | 1 | Device ready pin, asynchronous |
| pin_fifo_busy_i | input | 1 | Pin engine FIFO holds data |
| dma_req_o | output | 1 | DMA service request |
| dma_wr_valid_i | input | 1 | DMA byte offered (write to flash) |
| dma_wr_data_i | input | DATA_W | DMA byte |
| dma_wr_ready_o | output | 1 | DMA byte accepted |
| dma_rd_valid_o | output | 1 | Byte available to DMA (read from flash) |
| dma_rd_data_o | output | DATA_W | Byte to DMA |
| dma_rd_ready_i | input | 1 | DMA takes byte |
| dev_tx_valid_o | output | 1 | Byte available to pin engine |
| dev_tx_data_o | output | DATA_W | Byte to pin engine |
| dev_tx_ready_i | input | 1 | Pin engine takes byte |
| dev_rx_valid_i | input | 1 | Pin engine offers byte |
| dev_rx_data_i | input | DATA_W | Byte from pin engine |
| dev_rx_ready_o | output | 1 | Byte from pin engine accepted |
| ce_low_o | output | 1 | Force chip enable active |
| wide_bus_o | output | 1 | 16-bit device bus selected |
| ecc_en_o | output | 1 | ECC enable |
| dma_ecc_o | output | 1 | ECC during DMA enable |
| ecc_clr_o | output | 1 | One-cycle ECC accumulator clear |
| irq_o | output | 1 | Interrupt request |

## Verification
Register reads are combinational, so a register write shows up at the negedge after its clock edge. Handshake and request outputs are compared at every negedge of a transfer against a bench model of occupancy and remaining count, updated only for handshakes that were valid before the next edge. Completion is due two edges after the last byte leaves, status ready two edges after the pin rises, ready-pending one edge later, and the ECC pulse one edge after its write. Each check samples at the negedge that follows the counted edge and also checks the edge before, where one matters.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  typedef enum logic [2:0] {
    A_CTRL    = 3'd0,
    A_CFG     = 3'd1,
    A_STAT    = 3'd2,
    A_IRQ_RAW = 3'd3,
    A_IRQ_EN  = 3'd4,
    A_IRQ_SET = 3'd5,
    A_IRQ_CLR = 3'd6,
    A_XFER    = 3'd7
  } reg_addr_e;

  localparam int CTRL_START = 0;
  localparam int CTRL_ECCCL = 1;
  localparam int CTRL_SRST  = 2;

  localparam int CFG_W     = 6;
  localparam int CFG_WIDE  = 0;
  localparam int CFG_DIR   = 1;
  localparam int CFG_BURST = 2;
  localparam int CFG_ECC   = 3;
  localparam int CFG_DECC  = 4;
  localparam int CFG_CE    = 5;

  localparam int IRQ_N   = 2;
  localparam int IRQ_RDY = 0;
  localparam int IRQ_TC  = 1;
endpackage

// File: rtl/nfc_sync.sv
module nfc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/nfc_byte_fifo.sv
module nfc_byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [W-1:0]     din_i,
  input  logic             pop_i,
  output logic [W-1:0]     dout_o,
  output logic [OCC_W-1:0] occ_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [OCC_W-1:0] occ_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0; rp_q <= '0; occ_q <= '0;
    end else if (flush_i) begin
      wp_q <= '0; rp_q <= '0; occ_q <= '0;
    end else begin
      if (push_i) wp_q <= wp_q + 1'b1;
      if (pop_i)  rp_q <= rp_q + 1'b1;
      occ_q <= occ_q + OCC_W'(push_i) - OCC_W'(pop_i);
    end
  end

  assign dout_o = mem_q[rp_q];
  assign occ_o  = occ_q;

  // R3: flow control must never overrun or underrun the FIFO
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (occ_q != OCC_W'(DEPTH)));
  p_no_underflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (occ_q != '0));
endmodule

// File: rtl/nfc_irq_ctrl.sv
module nfc_irq_ctrl #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic [N-1:0] hw_set_i,
  input  logic [N-1:0] sw_set_i,
  input  logic [N-1:0] sw_clr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] pend_o,
  output logic         irq_o
);
  logic [N-1:0] pend_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    // hardware event wins over a same-cycle software clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       pend_q[i] <= 1'b0;
      else if (flush_i)  pend_q[i] <= 1'b0;
      else               pend_q[i] <= hw_set_i[i] | sw_set_i[i] | (pend_q[i] & ~sw_clr_i[i]);
    end

    p_event_pends_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hw_set_i[i] && !flush_i) |=> pend_q[i]);
    p_event_irq_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hw_set_i[i] && !flush_i && en_i[i]) |=> (irq_o || !en_i[i]));
  end

  assign pend_o = pend_q;
  assign irq_o  = |(pend_q & en_i);
endmodule

// File: rtl/nfc_xfer_ctrl.sv
module nfc_xfer_ctrl
  import nfc_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int FIFO_DEPTH  = 4,
  parameter int CNT_W       = 13,
  parameter int BURST_LEN   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        reg_addr_i,
  input  logic              reg_we_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              nand_rdy_i,
  input  logic              pin_fifo_busy_i,
  output logic              dma_req_o,
  input  logic              dma_wr_valid_i,
  input  logic [DATA_W-1:0] dma_wr_data_i,
  output logic              dma_wr_ready_o,
  output logic              dma_rd_valid_o,
  output logic [DATA_W-1:0] dma_rd_data_o,
  input  logic              dma_rd_ready_i,
  output logic              dev_tx_valid_o,
  output logic [DATA_W-1:0] dev_tx_data_o,
  input  logic              dev_tx_ready_i,
  input  logic              dev_rx_valid_i,
  input  logic [DATA_W-1:0] dev_rx_data_i,
  output logic              dev_rx_ready_o,
  output logic              ce_low_o,
  output logic              wide_bus_o,
  output logic              ecc_en_o,
  output logic              dma_ecc_o,
  output logic              ecc_clr_o,
  output logic              irq_o
);
  localparam int OCC_W = $clog2(FIFO_DEPTH + 1);

  logic             start_q, ecc_clr_q, rdy_prev_q;
  logic [CFG_W-1:0] cfg_q;
  logic [IRQ_N-1:0] ien_q, pend, hw_set, sw_set, sw_clr;
  logic [CNT_W-1:0] tc_q, occ_ext, free_ext, room_cnt, thr_w, thr_r;
  logic [OCC_W-1:0] occ;
  logic [DATA_W-1:0] src_data, fifo_dout;
  logic wr_ctrl, soft_rst, done, dir_rd, rdy_s, rdy_rise;
  logic src_valid, snk_ready, can_push, has_data, push, pop;
  logic req_single, req_burst;
  logic unused_wdata;

  assign unused_wdata = ^reg_wdata_i[31:CNT_W];

  assign wr_ctrl  = reg_we_i && (reg_addr_i == A_CTRL);
  assign soft_rst = wr_ctrl && reg_wdata_i[CTRL_SRST];
  assign done     = start_q && (tc_q == '0);
  assign dir_rd   = cfg_q[CFG_DIR];

  // data path
  assign occ_ext   = CNT_W'(occ);
  assign free_ext  = CNT_W'(FIFO_DEPTH) - occ_ext;
  assign room_cnt  = tc_q - occ_ext;
  assign src_valid = dir_rd ? dev_rx_valid_i : dma_wr_valid_i;
  assign src_data  = dir_rd ? dev_rx_data_i  : dma_wr_data_i;
  assign snk_ready = dir_rd ? dma_rd_ready_i : dev_tx_ready_i;
  assign can_push  = start_q && (occ != OCC_W'(FIFO_DEPTH)) && (room_cnt != '0);
  assign has_data  = start_q && (occ != '0);
  assign push      = can_push && src_valid;
  assign pop       = has_data && snk_ready;

  assign dma_wr_ready_o = can_push && !dir_rd;
  assign dev_rx_ready_o = can_push && dir_rd;
  assign dev_tx_valid_o = has_data && !dir_rd;
  assign dma_rd_valid_o = has_data && dir_rd;
  assign dev_tx_data_o  = fifo_dout;
  assign dma_rd_data_o  = fifo_dout;

  nfc_byte_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni, .flush_i(soft_rst), .push_i(push), .din_i(src_data),
    .pop_i(pop), .dout_o(fifo_dout), .occ_o(occ)
  );

  // request policy
  assign thr_w      = (room_cnt < CNT_W'(BURST_LEN)) ? room_cnt : CNT_W'(BURST_LEN);
  assign thr_r      = (tc_q < CNT_W'(BURST_LEN)) ? tc_q : CNT_W'(BURST_LEN);
  assign req_single = dir_rd ? has_data : can_push;
  assign req_burst  = dir_rd ? (has_data && occ_ext >= thr_r) : (can_push && free_ext >= thr_w);
  assign dma_req_o  = cfg_q[CFG_BURST] ? req_burst : req_single;

  // control state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0; cfg_q <= '0; ien_q <= '0; tc_q <= '0; ecc_clr_q <= 1'b0;
    end else begin
      ecc_clr_q <= wr_ctrl && reg_wdata_i[CTRL_ECCCL];
      if (soft_rst) begin
        start_q <= 1'b0; cfg_q <= '0; ien_q <= '0; tc_q <= '0;
      end else begin
        if (done)                                    start_q <= 1'b0;
        else if (wr_ctrl && reg_wdata_i[CTRL_START]) start_q <= 1'b1;
        if (reg_we_i && reg_addr_i == A_CFG)    cfg_q <= reg_wdata_i[CFG_W-1:0];
        if (reg_we_i && reg_addr_i == A_IRQ_EN) ien_q <= reg_wdata_i[IRQ_N-1:0];
        if (reg_we_i && reg_addr_i == A_XFER && !start_q) tc_q <= reg_wdata_i[CNT_W-1:0];
        else if (pop)                                      tc_q <= tc_q - 1'b1;
      end
    end
  end

  // ready pin and interrupts
  nfc_sync #(.STAGES(SYNC_STAGES)) u_rdy_sync (.clk_i, .rst_ni, .d_i(nand_rdy_i), .q_o(rdy_s));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdy_prev_q <= 1'b0;
    else         rdy_prev_q <= rdy_s;
  end

  assign rdy_rise        = rdy_s && !rdy_prev_q;
  assign hw_set[IRQ_RDY] = rdy_rise;
  assign hw_set[IRQ_TC]  = done;
  assign sw_set = (reg_we_i && reg_addr_i == A_IRQ_SET) ? reg_wdata_i[IRQ_N-1:0] : '0;
  assign sw_clr = (reg_we_i && reg_addr_i == A_IRQ_CLR) ? reg_wdata_i[IRQ_N-1:0] : '0;

  nfc_irq_ctrl #(.N(IRQ_N)) u_irq (
    .clk_i, .rst_ni, .flush_i(soft_rst), .hw_set_i(hw_set), .sw_set_i(sw_set),
    .sw_clr_i(sw_clr), .en_i(ien_q), .pend_o(pend), .irq_o
  );

  // register read
  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CTRL:    reg_rdata_o[CTRL_START] = start_q;
      A_CFG:     reg_rdata_o[CFG_W-1:0]  = cfg_q;
      A_STAT:    reg_rdata_o[2:0]        = {occ != '0, pin_fifo_busy_i, rdy_s};
      A_IRQ_RAW: reg_rdata_o[IRQ_N-1:0]  = pend;
      A_IRQ_EN:  reg_rdata_o[IRQ_N-1:0]  = ien_q;
      A_XFER:    reg_rdata_o[CNT_W-1:0]  = tc_q;
      default:   reg_rdata_o = '0;
    endcase
  end

  assign ce_low_o   = cfg_q[CFG_CE];
  assign wide_bus_o = cfg_q[CFG_WIDE];
  assign ecc_en_o   = cfg_q[CFG_ECC];
  assign dma_ecc_o  = cfg_q[CFG_DECC];
  assign ecc_clr_o  = ecc_clr_q;

  p_req_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_q |-> !dma_req_o);
  p_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !soft_rst) |=> (!start_q && pend[IRQ_TC]));
  p_count_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && !soft_rst) |=> (tc_q == $past(tc_q) - 1'b1));
  p_occ_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_ext <= tc_q);
  p_count_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_q && reg_we_i && reg_addr_i == A_XFER && !pop && !soft_rst) |=> $stable(tc_q));
  p_soft_reset_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> (!start_q && cfg_q == '0 && tc_q == '0 && occ == '0 && pend == '0));
endmodule

// File: tb/nfc_xfer_ctrl_bench.sv
module nfc_xfer_ctrl_bench;
  localparam int DEPTH = 4;
  localparam int BURST = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic reg_we = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic nand_rdy = 1'b0, pin_busy = 1'b0;
  logic dma_req, dma_wr_valid = 1'b0, dma_wr_ready, dma_rd_valid, dma_rd_ready = 1'b0;
  logic dev_tx_valid, dev_tx_ready = 1'b0, dev_rx_valid = 1'b0, dev_rx_ready;
  logic [7:0] dma_wr_data = '0, dma_rd_data, dev_tx_data, dev_rx_data = '0;
  logic ce_low, wide_bus, ecc_en, dma_ecc, ecc_clr, irq;
  int checks = 0, errors = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  nfc_xfer_ctrl u_nfc_xfer_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(reg_addr), .reg_we_i(reg_we),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .nand_rdy_i(nand_rdy),
    .pin_fifo_busy_i(pin_busy), .dma_req_o(dma_req),
    .dma_wr_valid_i(dma_wr_valid), .dma_wr_data_i(dma_wr_data), .dma_wr_ready_o(dma_wr_ready),
    .dma_rd_valid_o(dma_rd_valid), .dma_rd_data_o(dma_rd_data), .dma_rd_ready_i(dma_rd_ready),
    .dev_tx_valid_o(dev_tx_valid), .dev_tx_data_o(dev_tx_data), .dev_tx_ready_i(dev_tx_ready),
    .dev_rx_valid_i(dev_rx_valid), .dev_rx_data_i(dev_rx_data), .dev_rx_ready_o(dev_rx_ready),
    .ce_low_o(ce_low), .wide_bus_o(wide_bus), .ecc_en_o(ecc_en), .dma_ecc_o(dma_ecc),
    .ecc_clr_o(ecc_clr), .irq_o(irq)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic run_xfer(input int dir, input int burst, input int n, input logic [3:0] snk_pat);
    int acc = 0, dlv = 0, req_bad = 0, data_bad = 0, idle_bad = 0;
    int last_pop = -10, stop_cyc = -1;
    string t;
    t = $sformatf("dir=%0d burst=%0d n=%0d pat=%0h", dir, burst, n, snk_pat);
    wr(3'd1, 32'((dir << 1) | (burst << 2)));
    wr(3'd7, 32'(n));
    wr(3'd6, 32'd3);
    wr(3'd0, 32'd1);
    for (int cyc = 0; cyc < 300; cyc++) begin
      int occ, rem, room, thr;
      bit can_push, has, exp_req, sv, sr, pushf, popf;
      rd(3'd0, rv);
      if (rv[0] == 1'b0) begin stop_cyc = cyc; break; end
      sv = ((cyc % 4) != 0);
      sr = snk_pat[cyc % 4];
      dma_wr_valid = sv && dir == 0; dev_rx_valid = sv && dir == 1;
      dma_wr_data = 8'(n * 16 + acc); dev_rx_data = 8'(n * 16 + acc);
      dev_tx_ready = sr && dir == 0; dma_rd_ready = sr && dir == 1;
      #1;
      occ = acc - dlv; rem = n - dlv; room = rem - occ;
      can_push = (occ < DEPTH) && (room > 0);
      has = occ > 0;
      if (burst == 0) exp_req = dir ? has : can_push;
      else if (dir) begin
        thr = (rem < BURST) ? rem : BURST;
        exp_req = has && occ >= thr;
      end else begin
        thr = (room < BURST) ? room : BURST;
        exp_req = can_push && (DEPTH - occ) >= thr;
      end
      if (dma_req !== exp_req) req_bad++;
      if (dir == 0) begin
        if (dma_wr_ready !== can_push || dev_tx_valid !== has) req_bad++;
        if (dev_rx_ready || dma_rd_valid) idle_bad++;
        pushf = sv && dma_wr_ready; popf = sr && dev_tx_valid;
        if (popf && dev_tx_data !== 8'(n * 16 + dlv)) data_bad++;
      end else begin
        if (dev_rx_ready !== can_push || dma_rd_valid !== has) req_bad++;
        if (dma_wr_ready || dev_tx_valid) idle_bad++;
        pushf = sv && dev_rx_ready; popf = sr && dma_rd_valid;
        if (popf && dma_rd_data !== 8'(n * 16 + dlv)) data_bad++;
      end
      if (pushf) acc++;
      if (popf) begin dlv++; last_pop = cyc; end
      @(negedge clk);
    end
    dma_wr_valid = 0; dev_rx_valid = 0; dev_tx_ready = 0; dma_rd_ready = 0;
    chk({"R3 bytes delivered ", t}, dlv, n);
    chk({"R3 bytes accepted ", t}, acc, n);
    chk({"R4 byte order ", t}, data_bad, 0);
    chk({"R4 idle direction ports ", t}, idle_bad, 0);
    chk({"R6 request and handshake ", t}, req_bad, 0);
    chk({"R5 stop two cycles after last byte ", t}, stop_cyc, last_pop + 2);
    rd(3'd7, rv); chk({"R3 count zero ", t}, rv, 0);
    rd(3'd2, rv); chk({"R7 dma fifo empty ", t}, rv[2], 0);
    rd(3'd3, rv); chk({"R5 tc pending ", t}, rv[1], 1);
    chk({"R6 req low after stop ", t}, dma_req, 0);
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(3'd0, rv); chk("R1 ctrl", rv, 0);
    rd(3'd1, rv); chk("R1 cfg", rv, 0);
    rd(3'd2, rv); chk("R1 stat", rv, 0);
    rd(3'd3, rv); chk("R1 pending", rv, 0);
    rd(3'd4, rv); chk("R1 enable", rv, 0);
    rd(3'd7, rv); chk("R1 count", rv, 0);
    chk("R1 irq", irq, 0);
    chk("R1 dma_req", dma_req, 0);

    // R5 start with zero count
    wr(3'd0, 32'd1);
    rd(3'd0, rv); chk("R5 start visible with zero count", rv[0], 1);
    @(negedge clk);
    rd(3'd0, rv); chk("R5 start cleared", rv[0], 0);
    rd(3'd3, rv); chk("R5 tc pending on zero count", rv[1], 1);
    wr(3'd6, 32'd3);

    // transfer sweep, R3 R4 R5 R6
    for (int d = 0; d < 2; d++)
      for (int b = 0; b < 2; b++)
        for (int k = 0; k < 7; k++)
          for (int p = 0; p < 3; p++) begin
            int nl [7] = '{1, 2, 3, 4, 5, 6, 9};
            logic [3:0] pl [3] = '{4'hF, 4'h5, 4'h9};
            run_xfer(d, b, nl[k], pl[p]);
          end
    wr(3'd6, 32'd3);

    // R9 R10 set/clear/enable
    wr(3'd5, 32'd1);
    rd(3'd3, rv); chk("R9 set raises bit0", rv, 1);
    chk("R10 irq masked", irq, 0);
    wr(3'd4, 32'd1);
    chk("R10 irq enabled", irq, 1);
    rd(3'd3, rv); chk("R10 enable leaves pending", rv, 1);
    wr(3'd6, 32'd1);
    rd(3'd3, rv); chk("R9 clear bit0", rv, 0);
    chk("R10 irq after clear", irq, 0);
    wr(3'd5, 32'd3); wr(3'd4, 32'd2);
    chk("R10 irq tc enabled", irq, 1);
    wr(3'd6, 32'd2);
    chk("R10 irq tc cleared", irq, 0);
    rd(3'd3, rv); chk("R9 bit0 kept", rv, 1);
    wr(3'd5, 32'd2); wr(3'd6, 32'd3);
    rd(3'd3, rv); chk("R9 clear both", rv, 0);

    // R7 R8 ready pin
    wr(3'd4, 32'd1);
    nand_rdy = 1'b1;
    @(negedge clk);
    rd(3'd2, rv); chk("R7 ready after one edge", rv[0], 0);
    @(negedge clk);
    rd(3'd2, rv); chk("R7 ready after two edges", rv[0], 1);
    rd(3'd3, rv); chk("R8 pending not yet", rv[0], 0);
    @(negedge clk);
    rd(3'd3, rv); chk("R8 pending on rise", rv[0], 1);
    chk("R10 irq on ready", irq, 1);
    wr(3'd6, 32'd1);
    nand_rdy = 1'b0;
    repeat (4) @(negedge clk);
    rd(3'd3, rv); chk("R8 no pending on fall", rv[0], 0);
    rd(3'd2, rv); chk("R7 ready low", rv[0], 0);
    pin_busy = 1'b1;
    rd(3'd2, rv); chk("R7 pin fifo busy", rv[1], 1);
    pin_busy = 1'b0;

    // R12 cfg outputs and ecc pulse
    wr(3'd1, 32'h39);
    chk("R12 ce_low", ce_low, 1);
    chk("R12 wide_bus", wide_bus, 1);
    chk("R12 ecc_en", ecc_en, 1);
    chk("R12 dma_ecc", dma_ecc, 1);
    wr(3'd0, 32'd2);
    chk("R12 ecc clear pulse", ecc_clr, 1);
    @(negedge clk);
    chk("R12 ecc clear one cycle", ecc_clr, 0);

    // R2 count hold, R11 soft reset
    wr(3'd4, 32'd3);
    wr(3'd7, 32'd3);
    dma_wr_valid = 1'b1;
    wr(3'd0, 32'd1);
    repeat (6) @(negedge clk);
    rd(3'd2, rv); chk("R11 fifo filled", rv[2], 1);
    wr(3'd7, 32'd9);
    rd(3'd7, rv); chk("R2 count write ignored", rv, 3);
    wr(3'd0, 32'd5);
    dma_wr_valid = 1'b0;
    rd(3'd0, rv); chk("R11 start cleared", rv, 0);
    rd(3'd1, rv); chk("R11 cfg cleared", rv, 0);
    rd(3'd4, rv); chk("R11 enable cleared", rv, 0);
    rd(3'd7, rv); chk("R11 count cleared", rv, 0);
    rd(3'd2, rv); chk("R11 fifo flushed", rv[2], 0);
    chk("R11 req low", dma_req, 0);
    wr(3'd7, 32'd5);
    rd(3'd7, rv); chk("R2 idle count load", rv, 5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule